// File: doc/BRIEF.md
# Reduced-Storage Branch Metric Generator

This block forms the branch metrics of a rate-1/2 constituent code inside a Log-MAP turbo decoder. Each valid symbol brings three signed soft values, all already scaled by the channel reliability: the a priori term, the received systematic sample and the received parity sample. From them the block forms two half-terms. The first is half of (a priori + systematic). The second is half of the parity sample. The two metrics whose systematic bit is +1 are the sum and the difference of these half-terms. The two metrics whose systematic bit is -1 are the negations of those two.

Only the two metrics with systematic bit +1 go into a circular metric buffer. The buffer is sized for four acquisition windows. A delayed port reads the stored pair back a fixed number of symbols after it was written and rebuilds all four metrics from it by negation. The later LLR and extrinsic stages use this delayed port. Time in the buffer is counted in symbols, not clock cycles, so idle cycles between symbols do not change which symbol the delayed port returns.

Top module: `bm_gen_top`

## Requirements
- R1: For each valid symbol, the (+1,+1) metric equals sat(((apriori + sys) >>> 1) + (par >>> 1)). Here >>> is an arithmetic right shift on the full-precision signed sum, which rounds toward minus infinity.
- R2: The (+1,-1) metric equals sat(((apriori + sys) >>> 1) - (par >>> 1)).
- R3: The (-1,+1) metric equals the negation of the (+1,-1) metric. The (-1,-1) metric equals the negation of the (+1,+1) metric.
- R4: sat() clamps to the symmetric range -(2^(BM_W-1)-1) to +(2^(BM_W-1)-1), which is ±511 for 10-bit metrics. The value -512 never appears.
- R5: `cur_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. The current metric outputs keep their values while no symbol arrives.
- R6: When symbol n is accepted and n ≥ RD_LAG (symbols counted from 0 since reset), the delayed outputs in the same cycle as `cur_valid` carry the four metrics of symbol n-RD_LAG, rebuilt from the stored pair.
- R7: `dly_valid` is high only in cycles where `cur_valid` is high and at least RD_LAG symbols were stored before the current one.
- R8: Cycles with `in_valid` low do not advance the buffer, so the delay is measured in symbols.
- R9: A synchronous active-high reset clears both valid outputs and the buffer pointers. After reset, the delayed port fills again from symbol 0.
- R10: The delayed data stays correct after the write pointer wraps past the end of the DEPTH = 4*WIN_L entry buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Symbol strobe |
| apriori_in | input | IN_W | A priori soft value, signed |
| sys_in | input | IN_W | Channel-scaled systematic sample, signed |
| par_in | input | IN_W | Channel-scaled parity sample, signed |
| cur_valid | output | 1 | Current metrics valid |
| cur_pp | output | BM_W | Metric for (+1,+1) |
| cur_pm | output | BM_W | Metric for (+1,-1) |
| cur_mp | output | BM_W | Metric for (-1,+1) |
| cur_mm | output | BM_W | Metric for (-1,-1) |
| dly_valid | output | 1 | Delayed metrics valid |
| dly_pp | output | BM_W | Delayed (+1,+1) metric |
| dly_pm | output | BM_W | Delayed (+1,-1) metric |
| dly_mp | output | BM_W | Delayed (-1,+1) metric |
| dly_mm | output | BM_W | Delayed (-1,-1) metric |

## Verification
The hardest condition to reach from the ports is the wrap of the buffer. The write pointer passes the last entry while the read offset still points into the previous lap, and idle gaps sit between the symbols at the same time. The bench streams more than DEPTH symbols with irregular gaps and keeps its own history of the expected pairs, so a wrong wrap or a pointer that moves on idle cycles shows up as a mismatch on the delayed port. Saturation needs input values at the extremes of the signed range, and the bench drives these on purpose in both directions.

// File: rtl/bmg_pkg.sv
package bmg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store this symbol's pair
    logic dlyOk;   // the read entry holds a real symbol
  } bmg_strobe_t;
endpackage

// File: rtl/bmg_ctrl.sv
module bmg_ctrl #(
  parameter int DEPTH  = 160,
  parameter int RD_LAG = 120,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(RD_LAG + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output bmg_pkg::bmg_strobe_t strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAGA = AW'(RD_LAG % DEPTH);
  localparam logic [AW-1:0] WRAPADJ = AW'((DEPTH - (RD_LAG % DEPTH)) % DEPTH);
  localparam logic [CW-1:0] FULL = CW'(RD_LAG);

  logic [AW-1:0] wrPtr;
  logic [CW-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (inValid) begin
      wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    if (wrPtr >= LAGA) rdAddr = wrPtr - LAGA;
    else               rdAddr = wrPtr + WRAPADJ;
  end

  assign wrAddr       = wrPtr;
  assign strobe.wrEn  = inValid;
  assign strobe.dlyOk = inValid && (fillCnt == FULL);

  // R10
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(wrPtr) < DEPTH);
  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(inValid) && !$past(rst) |->
      int'(wrPtr) == (int'($past(wrPtr)) + 1) % DEPTH);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) && !$past(rst) |-> $stable(wrPtr) && $stable(fillCnt));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> wrPtr == '0 && fillCnt == '0);
endmodule

// File: rtl/bmg_datapath.sv
module bmg_datapath #(
  parameter int IN_W  = 10,
  parameter int BM_W  = 10,
  parameter int DEPTH = 160,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW = IN_W + 2
) (
  input  logic clk,
  input  logic rst,
  input  bmg_pkg::bmg_strobe_t strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic signed [IN_W-1:0] aprIn,
  input  logic signed [IN_W-1:0] sysIn,
  input  logic signed [IN_W-1:0] parIn,
  output logic curValid,
  output logic signed [BM_W-1:0] curPP,
  output logic signed [BM_W-1:0] curPM,
  output logic signed [BM_W-1:0] curMP,
  output logic signed [BM_W-1:0] curMM,
  output logic dlyValid,
  output logic signed [BM_W-1:0] dlyPP,
  output logic signed [BM_W-1:0] dlyPM,
  output logic signed [BM_W-1:0] dlyMP,
  output logic signed [BM_W-1:0] dlyMM
);
  localparam int LIM = 2 ** (BM_W - 1) - 1;
  localparam logic signed [SW-1:0] POS_LIM = SW'(LIM);
  localparam logic signed [SW-1:0] NEG_LIM = -SW'(LIM);

  logic signed [SW-1:0] sumA, thetaA, thetaB, rawP, rawM;
  logic signed [BM_W-1:0] satP, satM;
  logic [2*BM_W-1:0] metricMem [DEPTH];
  logic [2*BM_W-1:0] rdWord;

  function automatic logic signed [BM_W-1:0] clampBm(input logic signed [SW-1:0] v);
    if (v > POS_LIM)      return BM_W'(POS_LIM);
    else if (v < NEG_LIM) return BM_W'(NEG_LIM);
    else                  return v[BM_W-1:0];
  endfunction

  always_comb begin
    sumA   = SW'(aprIn) + SW'(sysIn);
    thetaA = sumA >>> 1;
    thetaB = SW'(parIn) >>> 1;
    rawP   = thetaA + thetaB;
    rawM   = thetaA - thetaB;
    satP   = clampBm(rawP);
    satM   = clampBm(rawM);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) metricMem[wrAddr] <= {satP, satM};
  end

  assign rdWord = metricMem[rdAddr];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      curPP <= satP;
      curPM <= satM;
      curMP <= -satM;
      curMM <= -satP;
      dlyPP <= rdWord[2*BM_W-1:BM_W];
      dlyPM <= rdWord[BM_W-1:0];
      dlyMP <= -rdWord[BM_W-1:0];
      dlyMM <= -rdWord[2*BM_W-1:BM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curValid <= 1'b0;
      dlyValid <= 1'b0;
    end else begin
      curValid <= strobe.wrEn;
      dlyValid <= strobe.dlyOk;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    curValid |-> int'(curPP) <= LIM && int'(curPP) >= -LIM &&
                 int'(curPM) <= LIM && int'(curPM) >= -LIM);
  // R3
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    curValid |-> int'(curMM) == -int'(curPP) && int'(curMP) == -int'(curPM));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.wrEn) |-> $stable(curPP) && $stable(curPM));
  // R7
  dly_sub_chk: assert property (@(posedge clk) disable iff (rst)
    dlyValid |-> curValid);
endmodule

// File: rtl/bm_gen_top.sv
module bm_gen_top #(
  parameter int IN_W   = 10,
  parameter int BM_W   = 10,
  parameter int WIN_L  = 40,
  parameter int RD_LAG = 3 * WIN_L,
  localparam int DEPTH = 4 * WIN_L,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic signed [IN_W-1:0] apriori_in,
  input  logic signed [IN_W-1:0] sys_in,
  input  logic signed [IN_W-1:0] par_in,
  output logic cur_valid,
  output logic signed [BM_W-1:0] cur_pp,
  output logic signed [BM_W-1:0] cur_pm,
  output logic signed [BM_W-1:0] cur_mp,
  output logic signed [BM_W-1:0] cur_mm,
  output logic dly_valid,
  output logic signed [BM_W-1:0] dly_pp,
  output logic signed [BM_W-1:0] dly_pm,
  output logic signed [BM_W-1:0] dly_mp,
  output logic signed [BM_W-1:0] dly_mm
);
  bmg_pkg::bmg_strobe_t strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  bmg_ctrl #(.DEPTH(DEPTH), .RD_LAG(RD_LAG)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(in_valid),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr));

  bmg_datapath #(.IN_W(IN_W), .BM_W(BM_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .aprIn(apriori_in), .sysIn(sys_in), .parIn(par_in),
    .curValid(cur_valid), .curPP(cur_pp), .curPM(cur_pm),
    .curMP(cur_mp), .curMM(cur_mm),
    .dlyValid(dly_valid), .dlyPP(dly_pp), .dlyPM(dly_pm),
    .dlyMP(dly_mp), .dlyMM(dly_mm));

  initial begin
    lag_range_chk: assert (RD_LAG >= 1 && RD_LAG <= DEPTH);
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cur_valid == $past(in_valid));
endmodule

// File: tb/test_bm_gen_top.sv
module test_bm_gen_top;
  localparam int IN_W = 10, BM_W = 10, WIN_L = 40, LAG = 3 * WIN_L, DEPTH = 4 * WIN_L;
  localparam int LIM = 2 ** (BM_W - 1) - 1;

  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [IN_W-1:0] apr = '0, sys = '0, par = '0;
  logic cur_valid, dly_valid;
  logic signed [BM_W-1:0] cur_pp, cur_pm, cur_mp, cur_mm, dly_pp, dly_pm, dly_mp, dly_mm;

  int checks = 0, errors = 0, symCnt = 0;
  int histP [1024];
  int histM [1024];

  always #2 clk = ~clk;

  bm_gen_top #(.IN_W(IN_W), .BM_W(BM_W), .WIN_L(WIN_L), .RD_LAG(LAG)) i_bm_gen_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .apriori_in(apr), .sys_in(sys), .par_in(par),
    .cur_valid(cur_valid), .cur_pp(cur_pp), .cur_pm(cur_pm), .cur_mp(cur_mp), .cur_mm(cur_mm),
    .dly_valid(dly_valid), .dly_pp(dly_pp), .dly_pm(dly_pm), .dly_mp(dly_mp), .dly_mm(dly_mm));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampI(input int v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  // drive at negedge, posedge captures, check at the following negedge
  task automatic sendSym(input int a, input int s, input int p, input int gap, input bit full);
    int t1, t2, ep, em;
    t1 = (a + s) >>> 1;
    t2 = p >>> 1;
    ep = clampI(t1 + t2);
    em = clampI(t1 - t2);
    apr = IN_W'(a); sys = IN_W'(s); par = IN_W'(p); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    histP[symCnt] = ep; histM[symCnt] = em;
    if (full) begin
      check(cur_valid == 1, "R5 cur_valid", int'(cur_valid), 1);
      check(int'(cur_pp) == ep, "R1 pp", int'(cur_pp), ep);
      check(int'(cur_pm) == em, "R2 pm", int'(cur_pm), em);
      check(int'(cur_mp) == -em && int'(cur_mm) == -ep, "R3 mp/mm", int'(cur_mm), -ep);
    end
    if (symCnt >= LAG) begin
      check(dly_valid == 1, "R7 dly_valid high", int'(dly_valid), 1);
      check(int'(dly_pp) == histP[symCnt-LAG] && int'(dly_pm) == histM[symCnt-LAG],
            "R6 delayed pair", int'(dly_pp), histP[symCnt-LAG]);
      check(int'(dly_mm) == -histP[symCnt-LAG] && int'(dly_mp) == -histM[symCnt-LAG],
            "R6 delayed negated", int'(dly_mm), -histP[symCnt-LAG]);
    end else begin
      check(dly_valid == 0, "R7 dly_valid low while filling", int'(dly_valid), 0);
    end
    symCnt++;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (full) begin
        check(cur_valid == 0 && dly_valid == 0, "R5 valid drops in gap", int'(cur_valid), 0);
        check(int'(cur_pp) == ep, "R5 hold in gap", int'(cur_pp), ep);
      end
    end
  endtask

  task automatic doReset();
    rst = 1; in_valid = 0;
    @(negedge clk); @(negedge clk);
    check(cur_valid == 0 && dly_valid == 0, "R9 reset clears valids", int'(cur_valid), 0);
    rst = 0;
    symCnt = 0;
  endtask

  task automatic testBasic();
    sendSym(10, 20, 6, 0, 1);
    sendSym(-3, 0, -5, 1, 1);     // negative rounding down
    sendSym(100, -40, 77, 0, 1);
    sendSym(0, 0, 0, 2, 1);
  endtask

  task automatic testSaturation();
    sendSym(511, 511, 511, 0, 1);   // R4 positive clamp
    sendSym(-512, -512, 511, 0, 1); // R4 negative clamp, never -512
    check(int'(cur_pm) == -LIM, "R4 clamp is -511", int'(cur_pm), -LIM);
    sendSym(-512, -512, -512, 0, 1);
    check(int'(cur_pp) == -LIM, "R4 pp -511", int'(cur_pp), -LIM);
  endtask

  task automatic testStream(input int n);
    // R8 and R10: irregular gaps while the pointer wraps
    for (int i = 0; i < n; i++)
      sendSym(((i * 37) % 1024) - 512, ((i * 91) % 1024) - 512, ((i * 53) % 700) - 350,
              (i % 5 == 0) ? 2 : ((i % 7 == 0) ? 1 : 0), 1);
  endtask

  initial begin
    fork
      begin
        doReset();
        testBasic();
        testSaturation();
        testStream(2 * DEPTH);   // R10 two wraps
        doReset();               // R9 refill from symbol 0
        testStream(LAG + 5);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule